// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

The block is a small configuration space that a host reaches through two byte-wide I/O ports. One address acts as the index port and the next as the data port. After reset the space is hidden. The host opens it by writing a four-byte key to the index port. Once the space is open, the host writes a register number to the index port and then reads or writes that register through the data port.

The space holds four kinds of register. The first is a logical-device select register. The second is a pair of read-only chip identification bytes. The third is a read-only revision nibble. The fourth is a two-byte I/O base address, and it is visible only while the GPIO logical device is selected. Writing the close command to the exit register hides the space again. The base address that has been programmed is driven out on a port so that downstream decode logic can use it.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the space is closed (`cfgOpen`=0), `gpioBase` is 0x0000, the logical-device select is 0x00 and `rdValid` is low.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in order to the index port (address 0x002E) opens the space. `cfgOpen` rises in the cycle after the fourth byte and not before.
- R3: A byte that does not match the expected key byte sends the key matcher back to its start. If that byte is 0x87, the match resumes at step two, so 0x87 0x01 0x55 0x87 0x01 0x55 0x55 opens the space.
- R4: While the space is closed, data-port reads return 0xFF and data-port writes change no register.
- R5: A read enable at the data port (address 0x002F) makes `rdValid` pulse high for exactly one cycle, one cycle later, with the byte on `ioRdData`. Reads at any other address produce no `rdValid`.
- R6: Register 0x07 is the logical-device select. It is writable and reads back the value last written.
- R7: Registers 0x20 and 0x21 return the high and low bytes of the chip ID parameter. Register 0x22 returns the revision in bits 3:0, and bits 7:4 read as zero.
- R8: Writes to registers 0x20, 0x21 and 0x22 have no effect on what those registers return.
- R9: While the logical-device select equals 0x07, register 0x62 holds the high byte of the base address and register 0x63 holds the low byte. Both are readable and both drive `gpioBase`. With any other device selected, writes to these registers are ignored and reads of them return 0x00.
- R10: Reads of any register that is not implemented return 0x00.
- R11: Writing 0x02 to register 0x02 closes the space. A write of any other value to register 0x02 leaves the space open. Register values survive the close.
- R12: Writes to I/O addresses other than the index and data ports change nothing, including the selected index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the current access |
| ioWrEn | input | 1 | Write strobe, one cycle per byte |
| ioRdEn | input | 1 | Read strobe, one cycle per byte |
| ioWrData | input | 8 | Write byte |
| ioRdData | output | 8 | Read byte, valid while rdValid is high |
| rdValid | output | 1 | Read data valid, one cycle after a data-port read |
| cfgOpen | output | 1 | High while the configuration space is open |
| gpioBase | output | 16 | Programmed GPIO I/O base address |

## Verification
The hardest case to reach is a key match that restarts in the middle of the sequence. The stimulus sends a stray 0x87 where the fourth key byte should be. It first checks that the space stays closed, then completes the key from step two and checks that the space opens. A second sequence places a wrong byte at step three and then sends the rest of the key, to show that no partial match survives. Writes made while the space is closed are checked after it opens, by reading back the registers they could have changed.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic dataRd;
    logic relock;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] IDX_ADDR  = 16'h002E,
  parameter logic [15:0] DATA_ADDR = 16'h002F,
  parameter logic [7:0]  EXIT_REG  = 8'h02,
  parameter logic [7:0]  EXIT_VAL  = 8'h02
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ioAddr,
  input  logic        ioWrEn,
  input  logic        ioRdEn,
  input  logic [7:0]  ioWrData,
  input  logic [7:0]  curIndex,
  output cfgStrobe_t  strobe,
  output logic        cfgOpen
);
  localparam int KEY_LEN = 4;
  localparam int STEP_W  = $clog2(KEY_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

  function automatic logic [7:0] keyByte(input logic [STEP_W-1:0] s);
    case (s)
      2'd0:    keyByte = 8'h87;
      2'd1:    keyByte = 8'h01;
      default: keyByte = 8'h55;
    endcase
  endfunction

  logic [STEP_W-1:0] keyStep;
  logic isIdx, isData, keyWr, relockHit;

  always_comb begin
    isIdx     = (ioAddr == IDX_ADDR);
    isData    = (ioAddr == DATA_ADDR);
    keyWr     = ioWrEn && isIdx && !cfgOpen;
    relockHit = ioWrEn && isData && cfgOpen &&
                (curIndex == EXIT_REG) && (ioWrData == EXIT_VAL);
    strobe.idxWr  = ioWrEn && isIdx && cfgOpen;
    strobe.dataWr = ioWrEn && isData && cfgOpen && !relockHit;
    strobe.dataRd = ioRdEn && isData;
    strobe.relock = relockHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyStep <= '0;
      cfgOpen <= 1'b0;
    end else begin
      if (keyWr) begin
        if (ioWrData == keyByte(keyStep)) begin
          if (keyStep == LAST_STEP) begin
            cfgOpen <= 1'b1;
            keyStep <= '0;
          end else begin
            keyStep <= keyStep + 1'b1;
          end
        end else if (ioWrData == keyByte('0)) begin
          keyStep <= STEP_W'(1);
        end else begin
          keyStep <= '0;
        end
      end
      if (relockHit) cfgOpen <= 1'b0;
    end
  end

  // R2: the space opens only on the final key byte
  assert_open_on_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOpen) |-> $past(keyWr && ioWrData == 8'h55 && keyStep == LAST_STEP));

  // R11: the close command shuts the space on the next cycle
  assert_relock_closes_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.relock |=> !cfgOpen);

  // R4: no register write strobe while closed
  assert_no_wr_when_closed_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOpen |-> !(strobe.dataWr || strobe.idxWr));
endmodule

// File: rtl/cfg_port_dp.sv
module cfg_port_dp
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h3,
  parameter logic [7:0]  BASE_REG = 8'h62,
  parameter logic [7:0]  GPIO_LDN = 8'h07
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strobe,
  input  logic        cfgOpen,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  curIndex,
  output logic [7:0]  ioRdData,
  output logic        rdValid,
  output logic [15:0] gpioBase
);
  localparam logic [7:0] LDN_REG  = 8'h07;
  localparam logic [7:0] IDHI_REG = 8'h20;
  localparam logic [7:0] IDLO_REG = 8'h21;
  localparam logic [7:0] REV_REG  = 8'h22;
  localparam logic [7:0] BASE_LO  = BASE_REG + 8'd1;
  localparam logic [7:0] LOCKED_RD = 8'hFF;

  logic [7:0] ldnSel;
  logic [7:0] readMux;
  logic       gpioSel;

  always_comb begin
    gpioSel = (ldnSel == GPIO_LDN);
    readMux = 8'h00;
    case (curIndex)
      LDN_REG:  readMux = ldnSel;
      IDHI_REG: readMux = CHIP_ID[15:8];
      IDLO_REG: readMux = CHIP_ID[7:0];
      REV_REG:  readMux = {4'h0, CHIP_REV};
      BASE_REG: readMux = gpioSel ? gpioBase[15:8] : 8'h00;
      BASE_LO:  readMux = gpioSel ? gpioBase[7:0]  : 8'h00;
      default:  readMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIndex <= '0;
      ldnSel   <= '0;
      gpioBase <= '0;
      ioRdData <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= strobe.dataRd;
      if (strobe.dataRd) ioRdData <= cfgOpen ? readMux : LOCKED_RD;
      if (strobe.idxWr) curIndex <= ioWrData;
      if (strobe.dataWr) begin
        if (curIndex == LDN_REG) ldnSel <= ioWrData;
        if (gpioSel && curIndex == BASE_REG) gpioBase[15:8] <= ioWrData;
        if (gpioSel && curIndex == BASE_LO)  gpioBase[7:0]  <= ioWrData;
      end
    end
  end

  // R4: a closed space reads as all ones
  assert_locked_read_ff_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRd && !cfgOpen) |=> (rdValid && ioRdData == 8'hFF));

  // R5: rdValid follows a data-port read by exactly one cycle
  assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataRd |=> rdValid);
  assert_rd_no_spurious_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataRd |=> !rdValid);

  // R9: the base address moves only on a data-port write
  assert_base_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataWr |=> $stable(gpioBase));

  // R7: the chip ID high byte reads back unchanged
  assert_id_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRd && cfgOpen && curIndex == IDHI_REG) |=> ioRdData == CHIP_ID[15:8]);
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h8728,
  parameter logic [3:0]  CHIP_REV  = 4'h3,
  parameter logic [15:0] IDX_ADDR  = 16'h002E,
  parameter logic [15:0] DATA_ADDR = 16'h002F,
  parameter logic [7:0]  BASE_REG  = 8'h62,
  parameter logic [7:0]  GPIO_LDN  = 8'h07
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ioAddr,
  input  logic        ioWrEn,
  input  logic        ioRdEn,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  ioRdData,
  output logic        rdValid,
  output logic        cfgOpen,
  output logic [15:0] gpioBase
);
  cfgStrobe_t strobe;
  logic [7:0] curIndex;

  cfg_port_ctrl #(
    .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR),
    .EXIT_REG(8'h02), .EXIT_VAL(8'h02)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .ioRdEn(ioRdEn), .ioWrData(ioWrData), .curIndex(curIndex),
    .strobe(strobe), .cfgOpen(cfgOpen)
  );

  cfg_port_dp #(
    .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV),
    .BASE_REG(BASE_REG), .GPIO_LDN(GPIO_LDN)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgOpen(cfgOpen),
    .ioWrData(ioWrData), .curIndex(curIndex), .ioRdData(ioRdData),
    .rdValid(rdValid), .gpioBase(gpioBase)
  );
endmodule

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;
  localparam logic [15:0] IDX  = 16'h002E;
  localparam logic [15:0] DATA = 16'h002F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData;
  logic rdValid, cfgOpen;
  logic [15:0] gpioBase;

  int checks = 0;
  int fails = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  keyed_cfg_port dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .rdValid(rdValid),
    .cfgOpen(cfgOpen), .gpioBase(gpioBase)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wr(IDX, idx);
    expQ.push_back(exp); tagQ.push_back(tag);
    ioAddr = DATA; ioRdEn = 1'b1;
    @(negedge clk);
    ioRdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic key();
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
  endtask

  // monitor: pop and compare each read result
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: unexpected rdValid, actual %h expected none", ioRdData);
      end else begin
        check(tagQ.pop_front(), {8'h00, ioRdData}, {8'h00, expQ.pop_front()});
      end
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 open", {15'd0, cfgOpen}, 16'd0);
    check("R1 base", gpioBase, 16'h0000);
    check("R1 rdValid", {15'd0, rdValid}, 16'd0);

    // closed: reads FF, writes dropped
    expQ.push_back(8'hFF); tagQ.push_back("R4 locked read");
    ioAddr = DATA; ioRdEn = 1'b1; @(negedge clk); ioRdEn = 1'b0; @(negedge clk);
    wr(DATA, 8'h07);
    // R5: read at non-data address gives no rdValid (monitor would flag it)
    ioAddr = 16'h0030; ioRdEn = 1'b1; @(negedge clk); ioRdEn = 1'b0; @(negedge clk);
    check("R5 no rdValid", {15'd0, rdValid}, 16'd0);

    // R3: wrong byte at step three
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h00); wr(IDX, 8'h55); wr(IDX, 8'h55);
    check("R3 wrong byte", {15'd0, cfgOpen}, 16'd0);
    // R3: 0x87 restarts at step two
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h87);
    check("R3 stray 87 closed", {15'd0, cfgOpen}, 16'd0);
    wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
    check("R3 restart opens", {15'd0, cfgOpen}, 16'd1);

    rdReg(8'h07, 8'h00, "R4 locked write ignored");
    rdReg(8'h20, 8'h87, "R7 id high");
    rdReg(8'h21, 8'h28, "R7 id low");
    rdReg(8'h22, 8'h03, "R7 revision");
    wr(IDX, 8'h20); wr(DATA, 8'h00);
    wr(IDX, 8'h22); wr(DATA, 8'hFF);
    rdReg(8'h20, 8'h87, "R8 id readonly");
    rdReg(8'h22, 8'h03, "R8 rev readonly");
    rdReg(8'h30, 8'h00, "R10 unimplemented");

    wr(IDX, 8'h07); wr(DATA, 8'h05);
    wr(IDX, 8'h62); wr(DATA, 8'h12);
    check("R9 other ldn write ignored", gpioBase, 16'h0000);
    rdReg(8'h62, 8'h00, "R9 other ldn read zero");
    rdReg(8'h07, 8'h05, "R6 ldn readback");
    wr(IDX, 8'h07); wr(DATA, 8'h07);
    wr(IDX, 8'h62); wr(DATA, 8'hA5);
    wr(IDX, 8'h63); wr(DATA, 8'h3C);
    check("R9 base out", gpioBase, 16'hA53C);
    rdReg(8'h62, 8'hA5, "R9 base high");

    // R12: index left at 0x62; foreign-address writes change nothing
    wr(16'h0030, 8'h20);
    wr(16'h002D, 8'h63);
    expQ.push_back(8'hA5); tagQ.push_back("R12 index kept");
    ioAddr = DATA; ioRdEn = 1'b1; @(negedge clk); ioRdEn = 1'b0; @(negedge clk);
    check("R12 base kept", gpioBase, 16'hA53C);

    // R11
    wr(IDX, 8'h02); wr(DATA, 8'h01);
    check("R11 other value stays open", {15'd0, cfgOpen}, 16'd1);
    wr(DATA, 8'h02);
    check("R11 closed", {15'd0, cfgOpen}, 16'd0);
    check("R11 base survives", gpioBase, 16'hA53C);

    // R2: exact key, opens only after fourth byte
    wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55);
    check("R2 not after three", {15'd0, cfgOpen}, 16'd0);
    wr(IDX, 8'h55);
    check("R2 opens", {15'd0, cfgOpen}, 16'd1);
    rdReg(8'h63, 8'h3C, "R2 R11 base low after reopen");

    repeat (3) @(negedge clk);
    check("R5 queue drained", 16'(expQ.size()), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule